// File: doc/BRIEF.md
# Reset Source Status Register

This block keeps a record of what caused the most recent reset of the chip. The reset controller raises one request line per source (power-on, external pin, PLL loss-of-lock, loss-of-clock, watchdog/debug, enabled checkstop and software system reset). It then pulses an acknowledge strobe for one cycle. On that strobe the block latches the highest-priority requested source into sticky status flags. It also captures the wake-up configuration pin and the two boot configuration pins.

Software reads the result through a 32-bit register port, where bit 0 is the most significant bit of the read word. The power-on flag has its own persistence rule: an external pin reset leaves it as it is, and any other acknowledged source clears it. The cause flags are exclusive, so only the flag of the latest acknowledged source is set.

The register also holds an error flag. A hardware event sets this flag, and software clears it by writing a one to it. One further bit is a general software-writable bit. All stored state returns to its initial values only on the asynchronous power-on reset input.

Top module: `reset_cause_reg`

## Requirements
- R1: While `porN` is low, and after it rises with no acknowledgement yet, a selected read returns 32'h8000_0000: bit 0 (read word bit 31) is 1 and every other bit is 0.
- R2: When `ackStrobe` is high and `srcReq` is nonzero, the lowest-indexed set request is latched. The index order is 0 power-on, 1 external, 2 loss-of-lock, 3 loss-of-clock, 4 watchdog/debug, 5 checkstop, 6 software. At most one of the cause flags is ever 1. Their positions are bit 1 external, bit 2 loss-of-lock, bit 3 loss-of-clock, bit 4 watchdog, bit 5 checkstop and bit 14 software, which are read word bits 30, 29, 28, 27, 26 and 17.
- R3: Bit 0 is set when a power-on source is acknowledged, and all cause flags are cleared at the same time. It keeps its value when the acknowledged source is the external pin. It is cleared when any other source is acknowledged.
- R4: Bit 15 (read word bit 16) is the error flag. It is set by `errSet`. A register write with data bit 15 equal to 1 clears it, and a write with that bit equal to 0 leaves it unchanged. If `errSet` and a clearing write happen in the same cycle, the flag ends up set.
- R5: Bit 31 (read word bit 0) takes data bit 31 on every register write. Writes have no effect on any other bit apart from the error clear.
- R6: On each acknowledgement that latches a source, bit 16 (read word bit 15) takes `wakePin`. Bits 29 and 30 (read word bits 2 and 1) take `bootPins[0]` and `bootPins[1]`.
- R7: Reserved bits 6–13 and 17–28 always read 0. When `regSel` is low, `rdData` is all zeros.
- R8: An acknowledgement with no request set, or requests without an acknowledgement, change no stored state.
- R9: A write takes effect only on a clock edge at which both `wrEn` and `regSel` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| ackStrobe | input | 1 | One-cycle acknowledgement from the reset controller |
| srcReq | input | 7 | Reset source requests, index 0 has the highest priority |
| wakePin | input | 1 | Wake-up configuration pin level |
| bootPins | input | 2 | Boot configuration pin levels |
| errSet | input | 1 | Sets the error flag |
| regSel | input | 1 | Register select |
| wrEn | input | 1 | Write enable |
| wrData | input | 32 | Write data, bit 0 is the MSB |
| rdData | output | 32 | Read data, bit 0 is the MSB |

## Verification
The bench builds the block with its package defaults: seven sources, two boot pins and a 32-bit word. This setting covers every priority pairing among the sources and exercises both sides of the power-on persistence rule. The random mix drives overlapping requests, which exercises the encoder, and it lands error set and clear in the same cycle. It also writes all-ones words, which show whether any reserved bit or other non-writable bit can be disturbed.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int SRC_COUNT = 7;
  localparam int CAUSE_COUNT = SRC_COUNT - 1;
  localparam int BOOT_W = 2;
  localparam int REG_W = 32;
  localparam int SRC_POR = 0;
  localparam int SRC_EXT = 1;
  // Register bit positions (bit 0 = MSB of the word)
  localparam int POS_POR = 0;
  localparam int POS_SW = 14;
  localparam int POS_ERR = 15;
  localparam int POS_WAKE = 16;
  localparam int POS_BOOT = 29;
  localparam int POS_SOFT = 31;

  typedef struct packed {
    logic captureEn;
    logic [SRC_COUNT-1:0] srcSel;
    logic errSetStb;
    logic errClrStb;
    logic softWrEn;
    logic softWrVal;
  } rss_strobe_t;

  // Map a register bit number (MSB-first) to a word index
  function automatic int wordIdx(input int pos);
    return REG_W - 1 - pos;
  endfunction

  // Cause flag k (source k+1) register bit position
  function automatic int causePos(input int k);
    return (k < CAUSE_COUNT - 1) ? k + 1 : POS_SW;
  endfunction
endpackage

// File: rtl/rss_ctrl.sv
module rss_ctrl
  import rss_pkg::*;
(
  input  logic                 ackStrobe,
  input  logic [SRC_COUNT-1:0] srcReq,
  input  logic                 errSet,
  input  logic                 regSel,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  output rss_strobe_t          stb
);
  logic [SRC_COUNT-1:0] pick;
  logic found;
  logic wrHit;
  logic unusedWr;

  // Fixed priority: lowest index wins
  always_comb begin
    found = 1'b0;
    for (int i = 0; i < SRC_COUNT; i++) begin
      pick[i] = srcReq[i] & ~found;
      found = found | srcReq[i];
    end
  end

  assign wrHit = wrEn & regSel;
  assign unusedWr = ^wrData;

  always_comb begin
    stb.captureEn = ackStrobe & found;
    stb.srcSel    = pick;
    stb.errSetStb = errSet;
    stb.errClrStb = wrHit & wrData[wordIdx(POS_ERR)];
    stb.softWrEn  = wrHit;
    stb.softWrVal = wrData[wordIdx(POS_SOFT)];
  end
endmodule

// File: rtl/rss_datapath.sv
module rss_datapath
  import rss_pkg::*;
(
  input  logic              clk,
  input  logic              porN,
  input  rss_strobe_t       stb,
  input  logic              wakePin,
  input  logic [BOOT_W-1:0] bootPins,
  input  logic              regSel,
  output logic [REG_W-1:0]  rdData
);
  logic porFlag;
  logic [CAUSE_COUNT-1:0] causeFlags;
  logic wakeCfg;
  logic [BOOT_W-1:0] bootCfg;
  logic errFlag;
  logic softBit;
  logic [REG_W-1:0] word;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      porFlag    <= 1'b1;
      causeFlags <= '0;
      wakeCfg    <= 1'b0;
      bootCfg    <= '0;
    end else if (stb.captureEn) begin
      if (stb.srcSel[SRC_POR]) porFlag <= 1'b1;
      else if (!stb.srcSel[SRC_EXT]) porFlag <= 1'b0;
      causeFlags <= stb.srcSel[SRC_COUNT-1:1];
      wakeCfg    <= wakePin;
      bootCfg    <= bootPins;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      errFlag <= 1'b0;
      softBit <= 1'b0;
    end else begin
      if (stb.errSetStb) errFlag <= 1'b1;
      else if (stb.errClrStb) errFlag <= 1'b0;
      if (stb.softWrEn) softBit <= stb.softWrVal;
    end
  end

  always_comb begin
    word = '0;
    word[wordIdx(POS_POR)] = porFlag;
    for (int k = 0; k < CAUSE_COUNT; k++)
      word[wordIdx(causePos(k))] = causeFlags[k];
    word[wordIdx(POS_ERR)]  = errFlag;
    word[wordIdx(POS_WAKE)] = wakeCfg;
    for (int b = 0; b < BOOT_W; b++)
      word[wordIdx(POS_BOOT + b)] = bootCfg[b];
    word[wordIdx(POS_SOFT)] = softBit;
  end

  assign rdData = regSel ? word : '0;
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rss_pkg::*;
(
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 ackStrobe,
  input  logic [SRC_COUNT-1:0] srcReq,
  input  logic                 wakePin,
  input  logic [BOOT_W-1:0]    bootPins,
  input  logic                 errSet,
  input  logic                 regSel,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     rdData
);
  rss_strobe_t stb;

  rss_ctrl u_ctrl (
    .ackStrobe(ackStrobe), .srcReq(srcReq), .errSet(errSet),
    .regSel(regSel), .wrEn(wrEn), .wrData(wrData), .stb(stb)
  );

  rss_datapath u_dp (
    .clk(clk), .porN(porN), .stb(stb), .wakePin(wakePin),
    .bootPins(bootPins), .regSel(regSel), .rdData(rdData)
  );
endmodule

// File: rtl/rss_checker.sv
module rss_checker
  import rss_pkg::*;
(
  input logic                 clk,
  input logic                 porN,
  input logic                 ackStrobe,
  input logic [SRC_COUNT-1:0] srcReq,
  input logic                 wakePin,
  input logic [BOOT_W-1:0]    bootPins,
  input logic                 errSet,
  input logic                 regSel,
  input logic                 wrEn,
  input logic [REG_W-1:0]     wrData,
  input logic [REG_W-1:0]     rdData
);
  localparam logic [REG_W-1:0] READABLE = 32'hFC03_8007;

  p_onehot_cause_r2: assert property (@(posedge clk) disable iff (!porN)
    regSel |-> $onehot0({rdData[30:26], rdData[17]}));

  p_por_clear_r3: assert property (@(posedge clk) disable iff (!porN)
    (ackStrobe && srcReq != '0 && !srcReq[0] && !srcReq[1])
      |=> (!regSel || !rdData[31]));

  p_por_keep_r3: assert property (@(posedge clk) disable iff (!porN)
    (ackStrobe && srcReq[1] && !srcReq[0] && regSel)
      |=> (!regSel || rdData[31] == $past(rdData[31])));

  p_err_set_r4: assert property (@(posedge clk) disable iff (!porN)
    errSet |=> (!regSel || rdData[16]));

  p_err_clr_r4: assert property (@(posedge clk) disable iff (!porN)
    (regSel && wrEn && wrData[16] && !errSet) |=> (!regSel || !rdData[16]));

  p_reserved_r7: assert property (@(posedge clk) disable iff (!porN)
    (rdData & ~READABLE) == '0);

  p_desel_r7: assert property (@(posedge clk) disable iff (!porN)
    !regSel |-> rdData == '0);

  p_idle_r8: assert property (@(posedge clk) disable iff (!porN)
    (regSel && !ackStrobe && !wrEn && !errSet) |=> (!regSel || $stable(rdData)));

  p_nowrite_r9: assert property (@(posedge clk) disable iff (!porN)
    (regSel && !wrEn && !ackStrobe) |=> (!regSel || rdData[0] == $past(rdData[0])));
endmodule

bind reset_cause_reg rss_checker u_chk (.*);

// File: tb/reset_cause_reg_tb.sv
module reset_cause_reg_tb;
  logic clk = 0;
  logic porN = 0;
  logic ackStrobe = 0;
  logic [6:0] srcReq = '0;
  logic wakePin = 0;
  logic [1:0] bootPins = '0;
  logic errSet = 0;
  logic regSel = 1;
  logic wrEn = 0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int nRun = 0;
  int nFail = 0;

  // model state
  logic mPor = 1;
  logic [5:0] mCause = '0;
  logic mWake = 0;
  logic [1:0] mBoot = '0;
  logic mErr = 0;
  logic mSoft = 0;

  always #5 clk = ~clk;

  reset_cause_reg u_dut (.*);

  function automatic logic [31:0] expWord();
    logic [31:0] w = '0;
    w[31] = mPor;
    w[30] = mCause[0]; w[29] = mCause[1]; w[28] = mCause[2];
    w[27] = mCause[3]; w[26] = mCause[4]; w[17] = mCause[5];
    w[16] = mErr; w[15] = mWake;
    w[2] = mBoot[0]; w[1] = mBoot[1];
    w[0] = mSoft;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    if (ackStrobe && srcReq != '0) begin
      int s = 0;
      while (!srcReq[s]) s++;
      if (s == 0) begin mPor = 1; mCause = '0; end
      else begin
        if (s != 1) mPor = 0;
        mCause = 6'(1 << (s - 1));
      end
      mWake = wakePin; mBoot = bootPins;
    end
    if (errSet) mErr = 1;
    else if (regSel && wrEn && wrData[16]) mErr = 0;
    if (regSel && wrEn) mSoft = wrData[0];
  endtask

  // drive one cycle, then check the selected read
  task automatic cyc(input string tag, input logic a, input logic [6:0] r,
                     input logic e, input logic sel, input logic we,
                     input logic [31:0] d, input logic wp, input logic [1:0] bp);
    ackStrobe = a; srcReq = r; errSet = e; regSel = sel; wrEn = we;
    wrData = d; wakePin = wp; bootPins = bp;
    @(posedge clk); #1;
    modelEdge();
    ackStrobe = 0; srcReq = '0; errSet = 0; wrEn = 0; regSel = 1;
    #1;
    chk(tag, rdData, expWord());
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #12;
    chk("R1 during reset", rdData, 32'h8000_0000);
    @(negedge clk); porN = 1;
    #1 chk("R1 after reset", rdData, 32'h8000_0000);

    // R8: requests without ack, ack without request
    cyc("R8 req no ack", 0, 7'h7E, 0, 1, 0, 0, 1, 2'b11);
    chk("R8 unchanged", rdData, 32'h8000_0000);
    cyc("R8 ack no req", 1, 7'h00, 0, 1, 0, 0, 1, 2'b11);
    // R3 external keeps power-on flag
    cyc("R3 ext keeps por", 1, 7'h02, 0, 1, 0, 0, 1, 2'b01);
    chk("R3 ext keeps por bit", {31'b0, rdData[31]}, 32'd1);
    // R2 priority: ext over watchdog; R6 pins
    cyc("R2 ext over wdg", 1, 7'h12, 0, 1, 0, 0, 0, 2'b10);
    cyc("R6 pins", 1, 7'h04, 0, 1, 0, 0, 1, 2'b11);
    chk("R3 lol clears por", {31'b0, rdData[31]}, 32'd0);
    cyc("R2 software bit14", 1, 7'h40, 0, 1, 0, 0, 0, 2'b00);
    cyc("R3 por sets", 1, 7'h7F, 0, 1, 0, 0, 1, 2'b01);
    // R4 error flag rules
    cyc("R4 set", 0, 0, 1, 1, 0, 0, 0, 0);
    cyc("R4 write 0 keeps", 0, 0, 0, 1, 1, 32'h0000_0000, 0, 0);
    cyc("R4 set wins", 0, 0, 1, 1, 1, 32'h0001_0000, 0, 0);
    cyc("R4 w1c", 0, 0, 0, 1, 1, 32'h0001_0000, 0, 0);
    // R5/R7 all-ones write
    cyc("R5 R7 ones", 0, 0, 0, 1, 1, 32'hFFFF_FFFF, 0, 0);
    chk("R5 soft bit", {31'b0, rdData[0]}, 32'd1);
    chk("R7 reserved", rdData & 32'h03FC_7FF8, 32'd0);
    // R9 write without select
    cyc("R9 no sel", 0, 0, 1, 0, 1, 32'h0000_0000, 0, 0);
    regSel = 0; #1;
    chk("R7 deselected", rdData, 32'd0);
    regSel = 1; #1;

    for (int i = 0; i < 400; i++) begin
      logic [6:0] r;
      r = 7'($urandom);
      if ($urandom % 4 != 0) r[0] = 0;
      cyc("R2 R3 R4 R5 R6 random", ($urandom % 2) == 1, r, ($urandom % 5) == 0,
          ($urandom % 8) != 0, ($urandom % 3) == 0, $urandom,
          ($urandom % 2) == 1, 2'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule